// File: doc/BRIEF.md
# Bus Speed Decoder

This block sits between a 24-bit CPU address bus and the memories and register blocks behind it. When the CPU starts a bus cycle, the block sorts the address into a target: cartridge ROM, work RAM (a small low window or the full two-bank area), the system register area, or nothing. It drives the chip select for that target and picks a cycle length in master clocks. It then holds the select for that many clocks and signals the last clock with a single done pulse.

The cycle length depends on three things: which half of the bank space the address falls in, a speed bit that software sets, and whether the access goes to registers. The lower banks always run ROM slowly. The upper banks run ROM fast only when the speed bit is set. Register accesses and internal CPU cycles always run at the fast rate, except for one legacy register window, which uses an extra-slow cycle. The speed bit clears on reset, so ROM is slow until software turns on fast access.

Top module: `bus_speed_decoder`

## Requirements
- R1: After reset, all chip selects, `bus_we` and `cyc_done` are low, `cyc_speed` reads 0 (idle), and the speed bit is 0, so a ROM cycle in bank 0x80 takes 8 clocks.
- R2: An access to ROM in banks 0x00-0x3F at offsets 0x8000-0xFFFF, or in banks 0x40-0x7D at any offset, asserts `cs_rom`, reports speed 2 (slow) and lasts 8 clocks.
- R3: An access to ROM in banks 0x80-0xFF asserts `cs_rom` and lasts 6 clocks with speed 1 (fast) when the speed bit is 1. It lasts 8 clocks with speed 2 when the bit is 0. Banks 0xFE-0xFF are ROM, not work RAM.
- R4: In banks 0x00-0x3F and 0x80-0xBF, offsets 0x2000-0x3FFF and 0x4200-0x5FFF assert `cs_regs` and run fast (6 clocks, speed 1), whatever the speed bit.
- R5: In those same banks, offsets 0x4000-0x41FF assert `cs_regs` and run extra slow (12 clocks, speed 3).
- R6: In those same banks, offsets 0x0000-0x1FFF assert `cs_wram` and run slow (8 clocks).
- R7: Banks 0x7E-0x7F at any offset assert `cs_wram` and run slow (8 clocks).
- R8: In banks 0x00-0x3F and 0x80-0xBF, offsets 0x6000-0x7FFF assert no select and run slow. Offsets below 0x8000 in other banks (other than 0x7E-0x7F) decode as ROM. At most one select is ever high.
- R9: A cycle started with `cyc_internal` high asserts no select and runs fast (6 clocks), whatever the address or the speed bit.
- R10: A cycle accepted at a clock edge shows its select and speed from the next clock onward. `cyc_done` is high only in the Nth clock, for one clock. A `cyc_start` while a cycle is busy is ignored, except during the done clock, where it starts the next cycle back to back.
- R11: `bus_we` equals the `cpu_wr` value sampled at the start edge, and is high only while a chip select is high.
- R12: `spd_we` loads `spd_bit` into the speed bit at a clock edge. A cycle started at that same edge uses the old value, and later cycles use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | Bus address, bank in bits 23:16 |
| cpu_wr | input | 1 | 1 = write, 0 = read, sampled at start |
| cyc_start | input | 1 | One-clock pulse that begins a bus cycle |
| cyc_internal | input | 1 | Cycle is an internal CPU operation with no bus target |
| spd_we | input | 1 | Load enable for the speed bit |
| spd_bit | input | 1 | New speed bit value (1 = fast upper-bank ROM) |
| cs_rom | output | 1 | ROM select |
| cs_wram | output | 1 | Work RAM select |
| cs_regs | output | 1 | System register select |
| cyc_speed | output | 2 | 0 idle, 1 fast, 2 slow, 3 extra slow |
| cyc_done | output | 1 | High in the last clock of the cycle |
| bus_we | output | 1 | Write strobe for the selected target |

## Verification
All outputs come from registers, so a start sampled at a rising edge shows its select, speed and write strobe in the clock that follows. `cyc_done` rises in clock 6, 8 or 12 after that edge, depending on the speed class. The bench keeps a behavioural model that updates on the same rising edge. It compares every output at each falling edge, halfway between edges, so the model and the design are always compared within the same clock. Each directed cycle is also timed by counting falling edges from the start until the done pulse, and that count is checked against 6, 8 or 12.

// File: rtl/bus_speed_pkg.sv
package bus_speed_pkg;
  typedef enum logic [1:0] {
    SPD_IDLE  = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_SLOW  = 2'd2,
    SPD_XSLOW = 2'd3
  } spd_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_WRAM = 2'd2,
    TGT_REGS = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    spd_e spd;
  } decode_t;
endpackage

// File: rtl/bsd_classify.sv
module bsd_classify
  import bus_speed_pkg::*;
#(
  parameter logic [6:0]  WRAM_PAIR   = 7'h3F,
  parameter logic [15:0] LOWRAM_LAST = 16'h1FFF,
  parameter logic [15:0] REG_FIRST   = 16'h2000,
  parameter logic [15:0] REG_LAST    = 16'h5FFF,
  parameter logic [15:0] XSLOW_FIRST = 16'h4000,
  parameter logic [15:0] XSLOW_LAST  = 16'h41FF,
  parameter logic [15:0] SYS_LAST    = 16'h7FFF
) (
  input  logic [23:0] addr,
  input  logic        internal,
  input  logic        fast_en,
  output decode_t     dec
);
  logic [7:0]  bank;
  logic [15:0] ofs;
  logic        sys_bank;
  logic        in_sys;
  logic        in_reg;
  logic        in_xslow;

  always_comb begin
    bank     = addr[23:16];
    ofs      = addr[15:0];
    sys_bank = ~bank[6];
    in_sys   = sys_bank && (ofs <= SYS_LAST);
    in_reg   = (ofs >= REG_FIRST) && (ofs <= REG_LAST);
    in_xslow = (ofs >= XSLOW_FIRST) && (ofs <= XSLOW_LAST);

    if (internal) begin
      dec.tgt = TGT_NONE;
      dec.spd = SPD_FAST;
    end else if (bank[7:1] == WRAM_PAIR) begin
      dec.tgt = TGT_WRAM;
      dec.spd = SPD_SLOW;
    end else if (in_sys) begin
      if (ofs <= LOWRAM_LAST) begin
        dec.tgt = TGT_WRAM;
        dec.spd = SPD_SLOW;
      end else if (in_reg) begin
        dec.tgt = TGT_REGS;
        dec.spd = in_xslow ? SPD_XSLOW : SPD_FAST;
      end else begin
        dec.tgt = TGT_NONE;
        dec.spd = SPD_SLOW;
      end
    end else begin
      dec.tgt = TGT_ROM;
      dec.spd = (bank[7] && fast_en) ? SPD_FAST : SPD_SLOW;
    end
  end
endmodule

// File: rtl/bsd_speed_ctl.sv
module bsd_speed_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic fast_en
);
  logic fast_d;

  always_comb begin
    fast_d = fast_en;
    if (wr_en) fast_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_en <= 1'b0;
    else        fast_en <= fast_d;
  end
endmodule

// File: rtl/bsd_cycle_timer.sv
module bsd_cycle_timer
  import bus_speed_pkg::*;
#(
  parameter int CLK_FAST  = 6,
  parameter int CLK_SLOW  = 8,
  parameter int CLK_XSLOW = 12,
  localparam int CNT_W    = $clog2(CLK_XSLOW)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  decode_t dec,
  input  logic    wr,
  output logic    busy_o,
  output logic    done_o,
  output tgt_e    tgt_o,
  output spd_e    spd_o,
  output logic    we_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  tgt_e             tgt_q, tgt_d;
  spd_e             spd_q, spd_d;
  logic             we_q, we_d;
  logic             accept;

  function automatic logic [CNT_W-1:0] last_count(input spd_e s);
    case (s)
      SPD_FAST:  last_count = CNT_W'(CLK_FAST - 1);
      SPD_XSLOW: last_count = CNT_W'(CLK_XSLOW - 1);
      default:   last_count = CNT_W'(CLK_SLOW - 1);
    endcase
  endfunction

  always_comb begin
    accept = start && (!busy_q || (cnt_q == '0));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    spd_d  = spd_q;
    we_d   = we_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = last_count(dec.spd);
      tgt_d  = dec.tgt;
      spd_d  = dec.spd;
      we_d   = wr && (dec.tgt != TGT_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= TGT_NONE;
      spd_q  <= SPD_IDLE;
      we_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      spd_q  <= spd_d;
      we_q   <= we_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
  assign tgt_o  = busy_q ? tgt_q : TGT_NONE;
  assign spd_o  = busy_q ? spd_q : SPD_IDLE;
  assign we_o   = busy_q && we_q;
endmodule

// File: rtl/bus_speed_decoder.sv
module bus_speed_decoder
  import bus_speed_pkg::*;
#(
  parameter int CLK_FAST  = 6,
  parameter int CLK_SLOW  = 8,
  parameter int CLK_XSLOW = 12,
  localparam int NSEL     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic        cyc_start,
  input  logic        cyc_internal,
  input  logic        spd_we,
  input  logic        spd_bit,
  output logic        cs_rom,
  output logic        cs_wram,
  output logic        cs_regs,
  output logic [1:0]  cyc_speed,
  output logic        cyc_done,
  output logic        bus_we
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic            fast_en;
  decode_t         dec;
  logic            busy;
  tgt_e            tgt;
  spd_e            spd;
  logic [NSEL-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bsd_speed_ctl u_speed (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (spd_we),
    .wr_bit  (spd_bit),
    .fast_en (fast_en)
  );

  bsd_classify u_class (
    .addr     (cpu_addr),
    .internal (cyc_internal),
    .fast_en  (fast_en),
    .dec      (dec)
  );

  bsd_cycle_timer #(
    .CLK_FAST  (CLK_FAST),
    .CLK_SLOW  (CLK_SLOW),
    .CLK_XSLOW (CLK_XSLOW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (cyc_start),
    .dec    (dec),
    .wr     (cpu_wr),
    .busy_o (busy),
    .done_o (cyc_done),
    .tgt_o  (tgt),
    .spd_o  (spd),
    .we_o   (bus_we)
  );

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = busy && (tgt == tgt_e'(2'(g + 1)));
  end

  assign cs_rom    = sel[0];
  assign cs_wram   = sel[1];
  assign cs_regs   = sel[2];
  assign cyc_speed = spd;
endmodule

// File: rtl/bus_speed_decoder_chk.sv
module bus_speed_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] bank_hi,
  input logic       cyc_start,
  input logic       cyc_internal,
  input logic       cs_rom,
  input logic       cs_wram,
  input logic       cs_regs,
  input logic [1:0] cyc_speed,
  input logic       cyc_done,
  input logic       bus_we
);
  logic idle_or_last;
  assign idle_or_last = (cyc_speed == 2'd0) || cyc_done;

  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_rom, cs_wram, cs_regs}));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  assert_hold_rom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rom && !cyc_done) |=> (cs_rom && $stable(cyc_speed)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_speed == 2'd0) |-> (!cs_rom && !cs_wram && !cs_regs && !cyc_done && !bus_we));

  assert_internal_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_internal && idle_or_last) |=>
      (cyc_speed == 2'd1 && !cs_rom && !cs_wram && !cs_regs));

  assert_we_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (cs_rom || cs_wram || cs_regs));

  assert_wram_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_internal && bank_hi == 7'h3F && idle_or_last) |=>
      (cs_wram && cyc_speed == 2'd2));
endmodule

bind bus_speed_decoder bus_speed_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .bank_hi      (cpu_addr[23:17]),
  .cyc_start    (cyc_start),
  .cyc_internal (cyc_internal),
  .cs_rom       (cs_rom),
  .cs_wram      (cs_wram),
  .cs_regs      (cs_regs),
  .cyc_speed    (cyc_speed),
  .cyc_done     (cyc_done),
  .bus_we       (bus_we)
);

// File: tb/bus_speed_decoder_test.sv
module bus_speed_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic        cpu_wr;
  logic        cyc_start;
  logic        cyc_internal;
  logic        spd_we;
  logic        spd_bit;
  logic        cs_rom, cs_wram, cs_regs;
  logic [1:0]  cyc_speed;
  logic        cyc_done;
  logic        bus_we;

  int    checks = 0;
  int    errs   = 0;
  int    ticks  = 0;
  bit    cmp_on = 0;

  bit    m_busy, m_spd, m_we;
  int    m_rem, m_tgt, m_code;
  string m_tag = "R1";
  bit    m_acc;
  int    t_tgt, t_code, t_len;
  string t_tag;

  always #2 clk = ~clk;

  bus_speed_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cyc_start(cyc_start), .cyc_internal(cyc_internal),
    .spd_we(spd_we), .spd_bit(spd_bit),
    .cs_rom(cs_rom), .cs_wram(cs_wram), .cs_regs(cs_regs),
    .cyc_speed(cyc_speed), .cyc_done(cyc_done), .bus_we(bus_we)
  );

  // target 0 none, 1 rom, 2 wram, 3 regs; code 1 fast, 2 slow, 3 extra slow
  function automatic void ref_class(input logic [23:0] a, input bit intl, input bit fast,
                                    output int tgt, output int code, output int len,
                                    output string tag);
    int bank = int'(a[23:16]);
    int ofs  = int'(a[15:0]);
    bit sysb = (bank < 'h40) || (bank >= 'h80 && bank < 'hC0);
    if (intl) begin
      tgt = 0; code = 1; len = 6; tag = "R9";
    end else if (bank == 'h7E || bank == 'h7F) begin
      tgt = 2; code = 2; len = 8; tag = "R7";
    end else if (sysb && ofs < 'h8000) begin
      if (ofs < 'h2000) begin
        tgt = 2; code = 2; len = 8; tag = "R6";
      end else if (ofs >= 'h4000 && ofs < 'h4200) begin
        tgt = 3; code = 3; len = 12; tag = "R5";
      end else if (ofs < 'h6000) begin
        tgt = 3; code = 1; len = 6; tag = "R4";
      end else begin
        tgt = 0; code = 2; len = 8; tag = "R8";
      end
    end else if (bank >= 'h80) begin
      tgt = 1; code = fast ? 1 : 2; len = fast ? 6 : 8; tag = "R3";
    end else begin
      tgt = 1; code = 2; len = 8; tag = (bank >= 'h40) ? "R8" : "R2";
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rem = 0; m_spd = 0; m_tgt = 0; m_code = 0; m_we = 0; m_tag = "R1";
    end else begin
      m_acc = cyc_start && (!m_busy || m_rem == 0);
      if (m_busy) begin
        if (m_rem == 0) m_busy = 0;
        else            m_rem = m_rem - 1;
      end
      if (m_acc) begin
        ref_class(cpu_addr, cyc_internal, m_spd, t_tgt, t_code, t_len, t_tag);
        m_busy = 1; m_rem = t_len - 1; m_tgt = t_tgt; m_code = t_code;
        m_we = cpu_wr && (t_tgt != 0); m_tag = t_tag;
      end
      if (spd_we) m_spd = spd_bit;
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check_val(m_busy ? m_tag : "R1",
                int'({cs_rom, cs_wram, cs_regs, cyc_speed}),
                int'({m_busy && m_tgt == 1, m_busy && m_tgt == 2, m_busy && m_tgt == 3,
                      m_busy ? 2'(m_code) : 2'd0}));
      check_val("R10", int'(cyc_done), int'(m_busy && m_rem == 0));
      check_val("R11", int'(bus_we), int'(m_busy && m_we));
    end
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", ticks, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_cycle(input logic [23:0] a, input bit wr, input bit intl,
                           input bit sw, input bit sv, input int exp_len, input string tag);
    int len;
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cyc_internal = intl; cyc_start = 1; spd_we = sw; spd_bit = sv;
    @(negedge clk);
    cyc_start = 0; spd_we = 0; len = 1;
    while (!cyc_done && len < 20) begin
      @(negedge clk);
      len++;
    end
    check_val(tag, len, exp_len);
    @(negedge clk);
  endtask

  task automatic set_speed(input bit v);
    @(negedge clk);
    spd_we = 1; spd_bit = v;
    @(negedge clk);
    spd_we = 0;
  endtask

  initial begin
    int len;
    rst_n = 0; cpu_addr = '0; cpu_wr = 0; cyc_start = 0; cyc_internal = 0;
    spd_we = 0; spd_bit = 0;
    repeat (3) @(negedge clk);
    check_val("R1", int'({cs_rom, cs_wram, cs_regs, cyc_speed, cyc_done, bus_we}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_val("R1", int'({cs_rom, cs_wram, cs_regs, cyc_speed, cyc_done, bus_we}), 0);
    cmp_on = 1;

    run_cycle(24'h808000, 0, 0, 0, 0, 8, "R1");
    run_cycle(24'h008000, 0, 0, 0, 0, 8, "R2");
    run_cycle(24'h7D1234, 1, 0, 0, 0, 8, "R2");
    run_cycle(24'h80FFFF, 1, 0, 0, 0, 8, "R3");
    set_speed(1);
    run_cycle(24'h808000, 0, 0, 0, 0, 6, "R3");
    run_cycle(24'hFE0010, 1, 0, 0, 0, 6, "R3");
    run_cycle(24'h3F8000, 0, 0, 0, 0, 8, "R2");
    run_cycle(24'h002100, 1, 0, 0, 0, 6, "R4");
    run_cycle(24'h804200, 0, 0, 0, 0, 6, "R4");
    run_cycle(24'h004016, 0, 0, 0, 0, 12, "R5");
    run_cycle(24'h8041FF, 1, 0, 0, 0, 12, "R5");
    run_cycle(24'h001FFF, 1, 0, 0, 0, 8, "R6");
    run_cycle(24'hBF0000, 0, 0, 0, 0, 8, "R6");
    run_cycle(24'h7E0000, 0, 0, 0, 0, 8, "R7");
    run_cycle(24'h7FFFFF, 1, 0, 0, 0, 8, "R7");
    run_cycle(24'h006000, 1, 0, 0, 0, 8, "R8");
    run_cycle(24'hC00100, 0, 0, 0, 0, 6, "R8");
    run_cycle(24'h400000, 0, 0, 0, 0, 8, "R8");
    run_cycle(24'h808000, 1, 1, 0, 0, 6, "R9");
    run_cycle(24'h004000, 1, 1, 0, 0, 6, "R9");
    // same-edge write of 0 keeps the old fast value for this cycle
    run_cycle(24'h808000, 0, 0, 1, 0, 6, "R12");
    run_cycle(24'h808000, 0, 0, 0, 0, 8, "R12");

    // R10: a start during a busy cycle is ignored
    @(negedge clk);
    cpu_addr = 24'h008000; cpu_wr = 0; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0; len = 1;
    @(negedge clk); len++;
    cpu_addr = 24'h002100; cyc_start = 1;
    @(negedge clk); len++;
    cyc_start = 0;
    while (!cyc_done && len < 20) begin
      @(negedge clk);
      len++;
    end
    check_val("R10", len, 8);

    // R10: a start in the done clock chains the next cycle
    cpu_addr = 24'h002100; cpu_wr = 1; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0; len = 1;
    check_val("R10", int'(cs_regs), 1);
    check_val("R11", int'(bus_we), 1);
    while (!cyc_done && len < 20) begin
      @(negedge clk);
      len++;
    end
    check_val("R10", len, 6);
    repeat (3) @(negedge clk);

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule